// File: doc/BRIEF.md
# Multimode Parallel Port Controller

This block is the host-side controller of a byte-wide parallel port. A 3-bit mode field in its extended control register selects the behaviour. The choices are manual drive of the data bus, bidirectional operation with a tri-stated bus, automatic transfer from a FIFO using the compatibility strobe handshake, and forward ECP transfers in which data bytes and command bytes share one FIFO. There are also a test mode with direct host access to the FIFO and a configuration mode that exposes two read-only configuration registers.

The host uses a simple synchronous register bus. Writes take effect at the clock edge. Reads are combinational from the address. The register offsets are: data at 0x000, status at 0x001, control at 0x002, the FIFO port at 0x400, configuration register B at 0x401, and the extended control register (ECR) at 0x402. In configuration mode, offset 0x400 returns configuration register A instead of the FIFO. The peripheral side has an 8-bit data bus with an output enable, an active-low strobe, a host-ack/command line, and the busy and ack inputs.

Top module: `mmpp_ctrl`

## Requirements
- R1: After reset the ECR reads 0x01 (mode 000 in bits 7:5, FIFO empty in bit 0, full in bit 1 clear), strobe_n is 1 and pd_oe is 1.
- R2: In mode 000 the FIFO is held empty, so a write to 0x400 leaves ECR bit 0 set. Control bit 5 reads 0 even after a 1 is written to it, the bus stays driven, and the data register appears on pd_out and reads back at 0x000.
- R3: In mode 001, control bit 5 can be written. When it is 1, pd_oe is 0 and a read of 0x000 returns pd_in. When it is 0, the read returns the data register again.
- R4: In mode 010, bytes written to 0x400 leave in write order. For each byte, pd_out holds the byte for at least one clock before strobe_n falls, and strobe_n stays low for exactly PULSE_CYCLES clocks. Outside mode 011, hostack carries the inverse of control bit 1.
- R5: A transfer does not start while busy is high. Once busy falls, the queued byte is sent.
- R6: In mode 011, a write to 0x400 queues a data byte and a write to 0x000 queues a command byte, both in one FIFO that keeps their order. During a data byte hostack is 1; during a command byte hostack is 0.
- R7: In mode 110 the host fills the FIFO through writes to 0x400 and empties it through reads of 0x400, in order. No strobe pulse occurs.
- R8: In mode 111, offset 0x400 reads 0x10 and offset 0x401 reads 0 in bit 7, the irq_line level in bit 6, and 0 in bits 5:0. In any other mode, offset 0x401 reads 0.
- R9: In modes 100 and 101, FIFO writes have no effect (ECR bit 0 stays 1) and no strobe pulse occurs.
- R10: ECR bit 1 is set once DEPTH bytes are held. Further writes are dropped, so exactly the first DEPTH bytes read back.
- R11: If a new mode is written to the ECR during a transfer, that byte's strobe pulse runs to completion and no new byte starts. The ECR mode field shows the old mode until the handshake has ended, and then shows the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 11 | Register offset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (pops the FIFO in test mode) |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational from address |
| irq_line | input | 1 | Interrupt line level, reported in configuration register B |
| pd_in | input | 8 | Data bus pin levels |
| pd_out | output | 8 | Data bus drive value |
| pd_oe | output | 1 | Data bus output enable |
| strobe_n | output | 1 | Strobe, active low |
| hostack | output | 1 | Host-ack / command line |
| busy | input | 1 | Peripheral busy |
| ack_n | input | 1 | Peripheral acknowledge, active low |

## Verification
A corrupted FIFO pointer or count shows up at the first strobe pulse that follows: the monitor sees a byte out of order, a duplicate, or a missing byte. In test mode the same fault appears in the next host read of the FIFO port, and a wrong full or empty flag appears in the next ECR read. A wrong handshake state appears within a few clocks as a strobe pulse of the wrong width, a pulse during busy, or a bus value that changes inside its setup window. A mode register updated at the wrong time appears in the ECR read taken just after the strobe rises, and also as a pulse with no matching expected byte.

// File: rtl/mmpp_pkg.sv
package mmpp_pkg;
   localparam int HOST_AW = 11;

   typedef enum logic [2:0] {
      MD_STD   = 3'b000,
      MD_BIDIR = 3'b001,
      MD_FIFO  = 3'b010,
      MD_ECP   = 3'b011,
      MD_RSV4  = 3'b100,
      MD_RSV5  = 3'b101,
      MD_TEST  = 3'b110,
      MD_CFG   = 3'b111
   } mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SETUP = 2'd1,
      ST_PULSE = 2'd2
   } hs_st_e;

   localparam logic [HOST_AW-1:0] OFS_DATA = 11'h000;
   localparam logic [HOST_AW-1:0] OFS_STAT = 11'h001;
   localparam logic [HOST_AW-1:0] OFS_CTRL = 11'h002;
   localparam logic [HOST_AW-1:0] OFS_FIFO = 11'h400;
   localparam logic [HOST_AW-1:0] OFS_CFGB = 11'h401;
   localparam logic [HOST_AW-1:0] OFS_ECR  = 11'h402;

   localparam logic [7:0] CFGA_VALUE = 8'h10;
endpackage

// File: rtl/mmpp_fifo.sv
module mmpp_fifo #(
   parameter int W     = 9,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("mmpp_fifo: DEPTH must be a power of two of at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("mmpp_fifo: W must be positive");
      end
   endgenerate

   logic [AW-1:0] wptr, rptr;
   logic [CW-1:0] count;
   logic [W-1:0]  mem [DEPTH];
   logic          push_ok, pop_ok;

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign rdata   = mem[rptr];

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_ent
         logic [W-1:0] ent_q;
         always_ff @(posedge clk) begin
            if (push_ok && wptr == AW'(i)) ent_q <= wdata;
         end
         assign mem[i] = ent_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else if (clr) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push_ok) wptr <= wptr + 1'b1;
         if (pop_ok)  rptr <= rptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R10: a write into a full FIFO leaves the fill level unchanged
   a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !clr) |=> full);

   // R10: the flags never claim both states together
   a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(full && empty));
endmodule

// File: rtl/mmpp_hs_eng.sv
module mmpp_hs_eng
   import mmpp_pkg::*;
#(
   parameter int PULSE_CYCLES = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic       busy,
   input  logic [8:0] din,
   output logic       pop,
   output logic [7:0] out_byte,
   output logic       out_tag,
   output logic       strobe_act,
   output logic       active
);
   generate
      if (PULSE_CYCLES < 1) begin : g_bad_pulse
         $error("mmpp_hs_eng: PULSE_CYCLES must be at least 1");
      end
   endgenerate

   hs_st_e st;
   logic   start, pulse_last;

   assign start      = (st == ST_IDLE) && go && !busy;
   assign pop        = start;
   assign strobe_act = (st == ST_PULSE);
   assign active     = (st != ST_IDLE);

   generate
      if (PULSE_CYCLES == 1) begin : g_single
         assign pulse_last = 1'b1;
      end else begin : g_count
         localparam int CNTW = $clog2(PULSE_CYCLES);
         logic [CNTW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          cnt <= '0;
            else if (st == ST_SETUP)             cnt <= CNTW'(PULSE_CYCLES - 1);
            else if (st == ST_PULSE && cnt != 0) cnt <= cnt - 1'b1;
         end
         assign pulse_last = (cnt == '0);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         out_byte <= '0;
         out_tag  <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: if (start) begin
               out_byte <= din[7:0];
               out_tag  <= din[8];
               st       <= ST_SETUP;
            end
            ST_SETUP: st <= ST_PULSE;
            ST_PULSE: if (pulse_last) st <= ST_IDLE;
            default:  st <= ST_IDLE;
         endcase
      end
   end

   // R4: the byte on the bus is held for the whole strobe pulse
   a_r4_data_held: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_PULSE) |-> $stable(out_byte));

   // R5: an idle engine with busy high stays idle
   a_r5_wait_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && busy) |=> (st == ST_IDLE));
endmodule

// File: rtl/mmpp_ctrl.sv
module mmpp_ctrl
   import mmpp_pkg::*;
#(
   parameter int DEPTH        = 16,
   parameter int PULSE_CYCLES = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [10:0]  host_addr,
   input  logic         host_wr,
   input  logic         host_rd,
   input  logic [7:0]   host_wdata,
   output logic [7:0]   host_rdata,
   input  logic         irq_line,
   input  logic [7:0]   pd_in,
   output logic [7:0]   pd_out,
   output logic         pd_oe,
   output logic         strobe_n,
   output logic         hostack,
   input  logic         busy,
   input  logic         ack_n
);
   localparam int FW = 9;

   mode_e      mode_q, mode_pend;
   logic [7:0] data_q;
   logic       dir_q;
   logic [3:0] ctl_lo_q;
   logic       dir_eff, xfer_mode, manual_mode;

   logic          fifo_push, fifo_pop, fifo_clr, fifo_empty, fifo_full;
   logic [FW-1:0] fifo_wdata, fifo_head;
   logic          eng_go, eng_pop, eng_tag, eng_strobe, eng_active;
   logic [7:0]    eng_byte;

   logic wr_data, wr_ctrl, wr_fifo, wr_ecr, rd_fifo;

   assign wr_data = host_wr && host_addr == OFS_DATA;
   assign wr_ctrl = host_wr && host_addr == OFS_CTRL;
   assign wr_fifo = host_wr && host_addr == OFS_FIFO;
   assign wr_ecr  = host_wr && host_addr == OFS_ECR;
   assign rd_fifo = host_rd && host_addr == OFS_FIFO;

   assign dir_eff     = (mode_q == MD_STD) ? 1'b0 : dir_q;
   assign xfer_mode   = (mode_q == MD_FIFO) || (mode_q == MD_ECP);
   assign manual_mode = (mode_q == MD_STD) || (mode_q == MD_BIDIR);

   // host-side registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q    <= '0;
         dir_q     <= 1'b0;
         ctl_lo_q  <= '0;
         mode_pend <= MD_STD;
      end else begin
         if (wr_data && mode_q != MD_ECP) data_q <= host_wdata;
         if (wr_ctrl) begin
            ctl_lo_q <= host_wdata[3:0];
            dir_q    <= (mode_q == MD_STD) ? 1'b0 : host_wdata[5];
         end
         if (wr_ecr) mode_pend <= mode_e'(host_wdata[7:5]);
      end
   end

   // the active mode follows the written one only between handshakes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           mode_q <= MD_STD;
      else if (!eng_active) mode_q <= mode_pend;
   end

   // FIFO routing
   always_comb begin
      fifo_push  = 1'b0;
      fifo_wdata = {1'b0, host_wdata};
      case (mode_q)
         MD_FIFO, MD_TEST: fifo_push = wr_fifo;
         MD_ECP: begin
            if (wr_fifo) begin
               fifo_push  = 1'b1;
               fifo_wdata = {1'b0, host_wdata};
            end else if (wr_data) begin
               fifo_push  = 1'b1;
               fifo_wdata = {1'b1, host_wdata};
            end
         end
         default: fifo_push = 1'b0;
      endcase
   end

   assign fifo_clr = (mode_q == MD_STD);
   assign fifo_pop = eng_pop || (rd_fifo && mode_q == MD_TEST);
   assign eng_go   = xfer_mode && !dir_eff && (mode_pend == mode_q) && !fifo_empty;

   mmpp_fifo #(.W(FW), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (fifo_clr),
      .push  (fifo_push),
      .wdata (fifo_wdata),
      .pop   (fifo_pop),
      .rdata (fifo_head),
      .empty (fifo_empty),
      .full  (fifo_full)
   );

   mmpp_hs_eng #(.PULSE_CYCLES(PULSE_CYCLES)) u_eng (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (eng_go),
      .busy       (busy),
      .din        (fifo_head),
      .pop        (eng_pop),
      .out_byte   (eng_byte),
      .out_tag    (eng_tag),
      .strobe_act (eng_strobe),
      .active     (eng_active)
   );

   // peripheral side
   assign pd_oe    = !dir_eff;
   assign pd_out   = xfer_mode ? eng_byte : data_q;
   assign strobe_n = manual_mode ? !ctl_lo_q[0] : !eng_strobe;
   assign hostack  = (mode_q == MD_ECP) ? !eng_tag : !ctl_lo_q[1];

   // read mux
   always_comb begin
      host_rdata = '0;
      case (host_addr)
         OFS_DATA: host_rdata = (mode_q == MD_BIDIR && dir_eff) ? pd_in : data_q;
         OFS_STAT: host_rdata = {busy, ack_n, 6'b0};
         OFS_CTRL: host_rdata = {2'b00, dir_eff, 1'b0, ctl_lo_q};
         OFS_FIFO: begin
            if (mode_q == MD_CFG)       host_rdata = CFGA_VALUE;
            else if (mode_q == MD_TEST) host_rdata = fifo_head[7:0];
         end
         OFS_CFGB: if (mode_q == MD_CFG) host_rdata = {1'b0, irq_line, 6'b0};
         OFS_ECR:  host_rdata = {mode_q, 3'b000, fifo_full, fifo_empty};
         default:  host_rdata = '0;
      endcase
   end

   // R2: standard mode keeps the FIFO empty
   a_r2_std_fifo_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_STD) |=> fifo_empty);

   // R8: configuration register B is hidden outside configuration mode
   a_r8_cfgb_hidden: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q != MD_CFG && host_addr == OFS_CFGB) |-> (host_rdata == 8'h00));

   // R9: reserved codes never produce a strobe
   a_r9_reserved_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MD_RSV4 || mode_q == MD_RSV5) |-> strobe_n);

   // R11: the active mode is frozen while a handshake runs
   a_r11_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
      eng_active |=> (mode_q == $past(mode_q)));
endmodule

// File: tb/mmpp_ctrl_bench.sv
module mmpp_ctrl_bench;
   localparam int DEPTH = 16;
   localparam int PULSE = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [10:0] host_addr = '0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [7:0]  host_wdata = '0, host_rdata;
   logic        irq_line = 1'b0;
   logic [7:0]  pd_in = '0, pd_out;
   logic        pd_oe, strobe_n, hostack;
   logic        busy = 1'b0, ack_n = 1'b1;

   always #2.5 clk = ~clk;

   mmpp_ctrl #(.DEPTH(DEPTH), .PULSE_CYCLES(PULSE)) u_mmpp_ctrl (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .irq_line(irq_line), .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe),
      .strobe_n(strobe_n), .hostack(hostack), .busy(busy), .ack_n(ack_n)
   );

   int n_chk = 0, n_fail = 0, pulses = 0;
   logic [8:0] exp_q[$];

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic host_write(input logic [10:0] a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic host_read(input logic [10:0] a, output logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_rd = 1'b1;
      #1 d = host_rdata;
      @(negedge clk);
      host_rd = 1'b0;
   endtask

   // driver: queue the expected {hostack, byte} then write it
   task automatic send(input logic [10:0] a, input logic [7:0] d, input logic ha);
      exp_q.push_back({ha, d});
      host_write(a, d);
   endtask

   task automatic set_mode(input logic [2:0] m);
      host_write(11'h402, {m, 5'b0});
      repeat (2) @(negedge clk);
   endtask

   task automatic wait_drain();
      for (int i = 0; i < 2000; i++) begin
         if (exp_q.size() == 0 && strobe_n) break;
         @(negedge clk);
      end
      repeat (4) @(negedge clk);
   endtask

   // monitor: pops the scoreboard on each strobe fall, checks setup and width
   logic       prev_sn = 1'b1;
   logic [7:0] prev_pd = '0;
   int         low_len = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_sn && !strobe_n) begin
            pulses++;
            low_len = 1;
            if (exp_q.size() == 0) check("R4 R7 R9 unexpected strobe", 1, 0);
            else begin
               logic [8:0] item;
               item = exp_q.pop_front();
               check("R4 R6 byte order and hostack", {hostack, pd_out}, item);
               check("R4 setup before strobe", prev_pd, pd_out);
            end
         end else if (!strobe_n) low_len++;
         else if (!prev_sn) check("R4 strobe width", low_len, PULSE);
         prev_sn = strobe_n;
         prev_pd = pd_out;
      end
   end

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] rd;
      int p0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      host_read(11'h402, rd); check("R1 ECR after reset", rd, 8'h01);
      check("R1 strobe_n idle", strobe_n, 1);
      check("R1 bus driven", pd_oe, 1);

      // R2 standard mode
      host_write(11'h002, 8'h20);
      host_read(11'h002, rd); check("R2 dir forced 0", rd, 8'h00);
      check("R2 bus driven", pd_oe, 1);
      host_write(11'h000, 8'hA5);
      check("R2 pd_out follows data reg", pd_out, 8'hA5);
      host_read(11'h000, rd); check("R2 data readback", rd, 8'hA5);
      host_write(11'h400, 8'h33);
      host_read(11'h402, rd); check("R2 FIFO held empty", rd, 8'h01);

      // R3 bidirectional mode
      set_mode(3'b001);
      host_write(11'h002, 8'h20);
      check("R3 bus released", pd_oe, 0);
      pd_in = 8'h3C;
      host_read(11'h000, rd); check("R3 reads pins", rd, 8'h3C);
      host_write(11'h002, 8'h00);
      host_read(11'h000, rd); check("R3 reads register", rd, 8'hA5);
      check("R3 bus driven again", pd_oe, 1);

      // R4 FIFO mode
      set_mode(3'b010);
      send(11'h400, 8'h11, 1'b1);
      send(11'h400, 8'h82, 1'b1);
      send(11'h400, 8'hF3, 1'b1);
      wait_drain();
      check("R4 all bytes sent", exp_q.size(), 0);

      // R5 busy holds off the transfer
      busy = 1'b1;
      p0 = pulses;
      send(11'h400, 8'h5A, 1'b1);
      repeat (30) @(negedge clk);
      check("R5 no strobe while busy", pulses, p0);
      busy = 1'b0;
      wait_drain();
      check("R5 byte sent after busy", pulses, p0 + 1);

      // R6 ECP mode, shared FIFO with tags
      set_mode(3'b011);
      send(11'h400, 8'hD1, 1'b1);
      send(11'h000, 8'hC2, 1'b0);
      send(11'h400, 8'hD3, 1'b1);
      send(11'h000, 8'hC4, 1'b0);
      wait_drain();
      check("R6 all ECP bytes sent", exp_q.size(), 0);

      // R7 / R10 test mode fill, full, drop, read back
      set_mode(3'b110);
      p0 = pulses;
      for (int i = 0; i < DEPTH; i++) host_write(11'h400, 8'(i * 3 + 1));
      host_read(11'h402, rd); check("R10 full flag", rd, 8'hC2);
      host_write(11'h400, 8'hEE);
      for (int i = 0; i < DEPTH; i++) begin
         host_read(11'h400, rd); check("R7 R10 FIFO readback", rd, 8'(i * 3 + 1));
      end
      host_read(11'h402, rd); check("R10 empty after drop", rd, 8'hC1);
      check("R7 no strobe in test mode", pulses, p0);

      // R8 configuration mode
      set_mode(3'b111);
      host_read(11'h400, rd); check("R8 cfgA", rd, 8'h10);
      irq_line = 1'b1;
      host_read(11'h401, rd); check("R8 cfgB irq high", rd, 8'h40);
      irq_line = 1'b0;
      host_read(11'h401, rd); check("R8 cfgB irq low", rd, 8'h00);
      set_mode(3'b110);
      irq_line = 1'b1;
      host_read(11'h401, rd); check("R8 cfgB hidden", rd, 8'h00);
      irq_line = 1'b0;

      // R9 reserved modes
      p0 = pulses;
      set_mode(3'b100);
      host_write(11'h400, 8'h55);
      host_read(11'h402, rd); check("R9 mode 100 ignores write", rd, 8'h81);
      set_mode(3'b101);
      host_write(11'h400, 8'h66);
      host_read(11'h402, rd); check("R9 mode 101 ignores write", rd, 8'hA1);
      set_mode(3'b110);
      host_read(11'h402, rd); check("R9 FIFO still empty", rd, 8'hC1);
      check("R9 no strobe", pulses, p0);

      // R11 mode change during a transfer
      set_mode(3'b000);
      set_mode(3'b010);
      busy = 1'b1;
      send(11'h400, 8'h11, 1'b1);
      host_write(11'h400, 8'h22);
      p0 = pulses;
      busy = 1'b0;
      for (int i = 0; i < 50; i++) begin
         @(negedge clk);
         if (!strobe_n) break;
      end
      host_write(11'h402, 8'hC0);
      host_read(11'h402, rd); check("R11 old mode until handshake ends", rd, 8'h40);
      repeat (10) @(negedge clk);
      host_read(11'h402, rd); check("R11 new mode applied", rd, 8'hC0);
      check("R11 exactly one pulse", pulses, p0 + 1);
      host_read(11'h400, rd); check("R11 second byte kept", rd, 8'h22);
      check("R4 scoreboard empty", exp_q.size(), 0);

      summary();
      $finish;
   end
endmodule